// File: doc/BRIEF.md
# Fault Response Retry Timer

This block decides what a single power channel does after a fault has shut it down. When the channel is running and a fault strobe arrives, the block drops the channel enable. What happens next depends on the response mode. In latched mode the channel stays dark until it is switched off and back on. In autonomous mode a countdown starts. When the countdown ends with the fault gone, the block re-enables the channel and asks for a fresh soft-start. When the fault is still there, the block begins another full wait, and it keeps doing so without limit.

The countdown runs on an external tick enable, nominally one pulse every 5 µs. The programmed delay is a tick count. It is clamped into a legal window that defaults to 120 ms at the low end and 83.88 s at the high end. An off command overrides everything in every state. The soft-start ramp, the fault detection and any bus decoding are outside the block.

Top module: `fault_retry_timer`

## Requirements
- R1: While reset is asserted, and at the first clock after it is released, the block is off: chanEn = 0 and softStartReq = 0.
- R2: When runCmd is high and the block is off, chanEn goes to 1 at the next clock edge and softStartReq is 1 for exactly that one cycle. softStartReq pulses only on entry to the running state.
- R3: In latched mode (autoRetry = 0), a faultStrobe while running clears chanEn at the next edge. The channel then stays off for as long as runCmd stays high, whatever faultPresent and tickEn do.
- R4: A latched-off channel returns to running, with a soft-start pulse, after runCmd is low for at least one cycle and then high again.
- R5: In autonomous mode (autoRetry = 1), a faultStrobe while running clears chanEn at the next edge and starts a wait of N ticks. If faultPresent is low in the cycle of the N-th tick, chanEn returns to 1 with a soft-start pulse at the following edge.
- R6: Only cycles with tickEn = 1 advance the wait. Other cycles leave it where it is.
- R7: If faultPresent is high in the cycle of the N-th tick, a new full wait of N ticks begins with the channel still off. This repeats with no limit on the number of retries.
- R8: N equals retryDelay when retryDelay lies within [MIN_TICKS, MAX_TICKS]. A value below MIN_TICKS is raised to MIN_TICKS (default 24000 ticks, 120 ms at 5 µs per tick).
- R9: A retryDelay above MAX_TICKS is lowered to MAX_TICKS (default 16776000 ticks, 83.88 s at 5 µs per tick). N is sampled when a wait starts.
- R10: runCmd low in any state sets chanEn to 0 at the next edge and cancels any wait in progress. A faultStrobe while the block is not running has no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous reset, active low |
| tickEn | input | 1 | Time-base tick enable, one cycle per tick |
| runCmd | input | 1 | Channel on/off command, 1 = on |
| autoRetry | input | 1 | Response mode, 1 = autonomous retry, 0 = latched |
| faultPresent | input | 1 | Level: the fault condition is still present |
| faultStrobe | input | 1 | One-cycle pulse: a fault requires shutdown |
| retryDelay | input | DELAY_W | Programmed retry delay in ticks |
| chanEn | output | 1 | Channel enable |
| softStartReq | output | 1 | One-cycle soft-start request |

## Verification
The bench goes after these boundaries:

- The exact tick on which a wait expires. A counter that is off by one re-enables the channel a tick early or a tick late, and the cycle-accurate model catches the shifted chanEn edge.
- A fault that persists through several expiries. A design that stops retrying, or that re-enables the channel regardless of the fault, departs from the model at the second expiry.
- Delays below and above the legal window. A missing clamp shortens or stretches the wait.
- Sparse tick enables. A timer that counts clock cycles instead of ticks would finish too early.
- An off command in the middle of a wait. A block that fails to cancel the wait would either resume the countdown or produce a spurious soft-start.

// File: rtl/frt_pkg.sv
`timescale 1ns/1ps
package frt_pkg;

  typedef enum logic [1:0] {
    ST_OFF     = 2'd0,
    ST_RUN     = 2'd1,
    ST_WAIT    = 2'd2,
    ST_LATCHED = 2'd3
  } chanState_e;

  // strobes from control to the countdown datapath
  typedef struct packed {
    logic load;   // load the clamped delay
    logic dec;    // count ticks
    logic clear;  // drop the count to zero
  } ctrlStrobe_t;

endpackage

// File: rtl/frt_datapath.sv
`timescale 1ns/1ps
module frt_datapath
  import frt_pkg::*;
#(
  parameter int DELAY_W   = 24,
  parameter int MIN_TICKS = 24000,
  parameter int MAX_TICKS = 16776000
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic               tickEn,
  input  logic [DELAY_W-1:0] retryDelay,
  input  ctrlStrobe_t        strobes,
  output logic               lastTick
);

  localparam logic [DELAY_W-1:0] MinCnt = DELAY_W'(MIN_TICKS);
  localparam logic [DELAY_W-1:0] MaxCnt = DELAY_W'(MAX_TICKS);
  localparam logic [DELAY_W-1:0] OneCnt = DELAY_W'(1);

  logic [DELAY_W-1:0] effDelay;
  logic [DELAY_W-1:0] remain;

  // clamp the programmed delay into the legal window
  always_comb begin
    if (retryDelay < MinCnt)      effDelay = MinCnt;
    else if (retryDelay > MaxCnt) effDelay = MaxCnt;
    else                          effDelay = retryDelay;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)                                    remain <= '0;
    else if (strobes.load)                        remain <= effDelay;
    else if (strobes.clear)                       remain <= '0;
    else if (strobes.dec && tickEn && remain != '0) remain <= remain - OneCnt;
  end

  // the tick in this cycle is the final tick of the wait
  assign lastTick = tickEn && (remain == OneCnt);

endmodule

// File: rtl/frt_ctrl.sv
`timescale 1ns/1ps
module frt_ctrl
  import frt_pkg::*;
(
  input  logic        clk,
  input  logic        rstN,
  input  logic        runCmd,
  input  logic        autoRetry,
  input  logic        faultPresent,
  input  logic        faultStrobe,
  input  logic        lastTick,
  output chanState_e  state,
  output ctrlStrobe_t strobes,
  output logic        chanEn,
  output logic        softStartReq
);

  chanState_e nextState;

  always_comb begin
    nextState = state;
    strobes   = '0;
    if (!runCmd) begin
      nextState = ST_OFF;
    end else begin
      case (state)
        ST_OFF: nextState = ST_RUN;
        ST_RUN: begin
          if (faultStrobe) begin
            if (autoRetry) begin
              nextState    = ST_WAIT;
              strobes.load = 1'b1;
            end else begin
              nextState = ST_LATCHED;
            end
          end
        end
        ST_WAIT: begin
          strobes.dec = 1'b1;
          if (lastTick) begin
            if (faultPresent) strobes.load = 1'b1;
            else              nextState    = ST_RUN;
          end
        end
        ST_LATCHED: nextState = ST_LATCHED;
        default:    nextState = ST_OFF;
      endcase
    end
    strobes.clear = (nextState != ST_WAIT);
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state        <= ST_OFF;
      chanEn       <= 1'b0;
      softStartReq <= 1'b0;
    end else begin
      state        <= nextState;
      chanEn       <= (nextState == ST_RUN);
      softStartReq <= (nextState == ST_RUN) && (state != ST_RUN);
    end
  end

endmodule

// File: rtl/fault_retry_timer.sv
`timescale 1ns/1ps
module fault_retry_timer
  import frt_pkg::*;
#(
  parameter int DELAY_W   = 24,
  parameter int MIN_TICKS = 24000,
  parameter int MAX_TICKS = 16776000
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic               tickEn,
  input  logic               runCmd,
  input  logic               autoRetry,
  input  logic               faultPresent,
  input  logic               faultStrobe,
  input  logic [DELAY_W-1:0] retryDelay,
  output logic               chanEn,
  output logic               softStartReq
);

  chanState_e  state;
  ctrlStrobe_t strobes;
  logic        lastTick;

  frt_ctrl u_ctrl (
    .clk          (clk),
    .rstN         (rstN),
    .runCmd       (runCmd),
    .autoRetry    (autoRetry),
    .faultPresent (faultPresent),
    .faultStrobe  (faultStrobe),
    .lastTick     (lastTick),
    .state        (state),
    .strobes      (strobes),
    .chanEn       (chanEn),
    .softStartReq (softStartReq)
  );

  frt_datapath #(
    .DELAY_W   (DELAY_W),
    .MIN_TICKS (MIN_TICKS),
    .MAX_TICKS (MAX_TICKS)
  ) u_dp (
    .clk        (clk),
    .rstN       (rstN),
    .tickEn     (tickEn),
    .retryDelay (retryDelay),
    .strobes    (strobes),
    .lastTick   (lastTick)
  );

endmodule

// File: rtl/frt_checker.sv
`timescale 1ns/1ps
module frt_checker
  import frt_pkg::*;
(
  input logic       clk,
  input logic       rstN,
  input logic       runCmd,
  input logic       chanEn,
  input logic       softStartReq,
  input chanState_e state
);

  p_pulse_single_r2: assert property (@(posedge clk) disable iff (!rstN)
    softStartReq |=> !softStartReq);

  p_pulse_with_en_r2: assert property (@(posedge clk) disable iff (!rstN)
    softStartReq |-> chanEn);

  p_rise_pulses_r2: assert property (@(posedge clk) disable iff (!rstN)
    $rose(chanEn) |-> softStartReq);

  p_latched_hold_r3: assert property (@(posedge clk) disable iff (!rstN)
    (state == ST_LATCHED && runCmd) |=> (state == ST_LATCHED && !chanEn));

  p_wait_dark_r5: assert property (@(posedge clk) disable iff (!rstN)
    (state == ST_WAIT) |-> !chanEn);

  p_off_cmd_r10: assert property (@(posedge clk) disable iff (!rstN)
    !runCmd |=> (!chanEn && state == ST_OFF));

endmodule

bind fault_retry_timer frt_checker u_chk (
  .clk          (clk),
  .rstN         (rstN),
  .runCmd       (runCmd),
  .chanEn       (chanEn),
  .softStartReq (softStartReq),
  .state        (state)
);

// File: tb/tb_fault_retry_timer.sv
`timescale 1ns/1ps
module tb_fault_retry_timer;

  localparam int DW   = 8;
  localparam int MINT = 20;
  localparam int MAXT = 60;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic tickEn = 1'b1;
  logic runCmd = 1'b0;
  logic autoRetry = 1'b0;
  logic faultPresent = 1'b0;
  logic faultStrobe = 1'b0;
  logic [DW-1:0] retryDelay = 8'd30;
  logic chanEn, softStartReq;

  int total = 0;
  int fails = 0;
  bit checking = 1'b0;
  bit finished = 1'b0;
  string reqTag = "R1";

  // reference model: 0 off, 1 run, 2 wait, 3 latched
  int  mState = 0;
  int  waited = 0;
  int  target = 0;
  logic expEn = 1'b0;
  logic expPulse = 1'b0;

  always #10 clk = ~clk;

  fault_retry_timer #(.DELAY_W(DW), .MIN_TICKS(MINT), .MAX_TICKS(MAXT)) dut (
    .clk(clk), .rstN(rstN), .tickEn(tickEn), .runCmd(runCmd),
    .autoRetry(autoRetry), .faultPresent(faultPresent),
    .faultStrobe(faultStrobe), .retryDelay(retryDelay),
    .chanEn(chanEn), .softStartReq(softStartReq)
  );

  function automatic int clampDelay(int d);
    if (d < MINT) return MINT;
    if (d > MAXT) return MAXT;
    return d;
  endfunction

  always @(posedge clk) begin
    int nxt;
    if (!rstN) begin
      mState = 0; waited = 0; expPulse = 1'b0;
    end else begin
      nxt = mState;
      if (!runCmd) nxt = 0;
      else case (mState)
        0: nxt = 1;
        1: if (faultStrobe) begin
             if (autoRetry) begin nxt = 2; waited = 0; target = clampDelay(int'(retryDelay)); end
             else nxt = 3;
           end
        2: if (tickEn) begin
             waited = waited + 1;
             if (waited == target) begin
               if (faultPresent) begin waited = 0; target = clampDelay(int'(retryDelay)); end
               else nxt = 1;
             end
           end
        default: nxt = mState;
      endcase
      expPulse = (nxt == 1) && (mState != 1);
      mState = nxt;
    end
    expEn = (mState == 1);
  end

  task automatic check(string what, logic act, logic exp);
    total++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s %s at %0t: actual=%0b expected=%0b", reqTag, what, $time, act, exp);
    end
  endtask

  always @(negedge clk) begin
    if (checking) begin
      check("chanEn", chanEn, expEn);
      check("softStartReq", softStartReq, expPulse);
    end
  end

  task automatic cycles(int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  task automatic strobeFault();
    faultStrobe = 1'b1;
    @(negedge clk);
    faultStrobe = 1'b0;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      total++; fails++;
      $display("FAIL watchdog: actual=timeout expected=completion");
      $display("%0d/%0d checks passed", total - fails, total);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd4711));
    checking = 1'b1;
    reqTag = "R1"; cycles(3);
    rstN = 1'b1; cycles(2);

    reqTag = "R2"; runCmd = 1'b1; autoRetry = 1'b0; cycles(4);

    reqTag = "R3"; faultPresent = 1'b0; strobeFault(); cycles(80);
    faultPresent = 1'b1; cycles(10); faultPresent = 1'b0;

    reqTag = "R4"; runCmd = 1'b0; cycles(1); runCmd = 1'b1; cycles(5);

    reqTag = "R5"; autoRetry = 1'b1; retryDelay = 8'd30; strobeFault(); cycles(40);

    reqTag = "R6";
    strobeFault();
    for (int i = 0; i < 90; i++) begin tickEn = ($urandom_range(0, 1) == 1); @(negedge clk); end
    tickEn = 1'b1; cycles(5);

    reqTag = "R7"; faultPresent = 1'b1; strobeFault(); cycles(95);
    faultPresent = 1'b0; cycles(40);

    reqTag = "R8"; retryDelay = 8'd3; strobeFault(); cycles(30);
    retryDelay = 8'd20; strobeFault(); cycles(30);

    reqTag = "R9"; retryDelay = 8'd200; strobeFault(); cycles(70);

    reqTag = "R10"; retryDelay = 8'd30; strobeFault(); cycles(10);
    runCmd = 1'b0; strobeFault(); cycles(2); strobeFault(); cycles(40);
    runCmd = 1'b1; cycles(5);
    autoRetry = 1'b0; strobeFault(); cycles(3);
    runCmd = 1'b0; cycles(3); runCmd = 1'b1; cycles(3);

    reqTag = "R5";
    for (int i = 0; i < 4000; i++) begin
      runCmd = ($urandom_range(0, 149) != 0);
      if ($urandom_range(0, 199) == 0) autoRetry = ~autoRetry;
      faultStrobe = ($urandom_range(0, 39) == 0);
      if ($urandom_range(0, 19) == 0) faultPresent = ~faultPresent;
      tickEn = ($urandom_range(0, 9) < 7);
      if ($urandom_range(0, 49) == 0) retryDelay = DW'($urandom_range(0, 255));
      @(negedge clk);
    end
    faultStrobe = 1'b0;
    cycles(2);

    finished = 1'b1;
    checking = 1'b0;
    $display("%0d/%0d checks passed", total - fails, total);
    $finish;
  end

endmodule